// File: doc/BRIEF.md
# Autonomous Data-Phase and Disconnect Sequencer

This block is the initiator-side control engine that carries a combined select-with-attention-and-transfer command through its data phase without processor help. Once a command is armed with a byte count and a target ID, the block moves bytes through the data phase and decrements the transfer count. It handles pointer-save and disconnect messages, follows the target through a legal disconnect and a later reconnect, and reports the outcome as a 4-bit command state code plus single-cycle interrupt pulses.

Three policy inputs change how it reacts. The halt-on-parity control stops the transfer at the first bad data byte. The attention-on-parity control raises ATN when a data byte is bad. The halt-on-disconnect control ends the command when the target leaves the bus, instead of waiting for the target to come back. The byte handshake, the FIFO, arbitration and selection sit outside this block and reach it as single-cycle strobes. Message decoding also sits outside: the save-pointer, disconnect and command-complete messages arrive as strobes.

State codes used: 0 after reset, 4 when armed, 5 in the data phase, 6 after a pointer save, 7 after a disconnect message, 8 when disconnected, and hexadecimal B when the count is exhausted.

Top module: `dp_disc_seq`

## Requirements
- R1: After reset, `state_code` is 0, `atn` is 0, and no interrupt or `cnt_dec` pulse is present.
- R2: `cmd_start` in the idle or halted state loads `xfer_len` and `tgt_id` and sets the code to 4. A later `req` while `bus_data`=1 sets the code to 5.
- R3: In the data phase, each `byte_ack` with `bus_data`=1 and no parity error gives one `cnt_dec` pulse. The byte that takes the count to zero also sets the code to hexadecimal B.
- R4: With `cfg_hpe`=1, a data byte with `par_err` raises `irq_halt` and `irq_par` in the same cycle and gives no `cnt_dec`. The code stays 5, and later `byte_ack` strobes give no `cnt_dec`.
- R5: With `cfg_hpe`=0, a bad data byte still counts and the transfer goes on. The command then ends with `irq_halt` and `irq_par`: on the last byte (code B), or when `bus_data` falls (code stays 5).
- R6: `atn` rises only for a data-byte parity error while `cfg_aape`=1, and holds until the next `cmd_start` or reset. A parity error on a byte with `bus_data`=0 ends the command with `irq_halt` and `irq_par` and leaves `atn` low.
- R7: `msg_sdp` in the data phase sets the code to 6, and `req` with `bus_data`=1 then returns it to 5. `msg_disc` is accepted (code 7) only when the code is 4 or 6. In the data phase it is ignored and the code stays 5.
- R8: `bus_free` after an accepted disconnect message sets the code to 8. With `cfg_hd`=1 it also gives one `irq_disc` pulse and the command ends.
- R9: With `cfg_hd`=0, `resel` with `resel_id` equal to the armed target sets the code to 5. Counting then resumes from the remaining count.
- R10: While disconnected, `resel` from another ID pulses `irq_resel`, and `sel_in` pulses `irq_sel`. The code stays 8 in both cases.
- R11: `bus_free` at any other point in an active command (no preceding disconnect message, and no command-complete message after code B) pulses `irq_ctl_err` and sets the code to 8. After that, every input, `cmd_start` included, is ignored until reset.
- R12: At code B, `msg_cmplt` followed by `bus_free` ends the command without `irq_ctl_err`, and the code stays B.
- R13: Every interrupt output and `cnt_dec` lasts exactly one clock cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Arm a new command |
| xfer_len | input | CNT_W | Byte count loaded at arm time (nonzero) |
| tgt_id | input | ID_W | Target ID of the command |
| bus_data | input | 1 | Bus is in a data phase |
| req | input | 1 | Target request seen |
| byte_ack | input | 1 | One byte completed its handshake |
| par_err | input | 1 | Parity error on the current byte |
| msg_sdp | input | 1 | Save-pointer message received |
| msg_disc | input | 1 | Disconnect message received |
| msg_cmplt | input | 1 | Command-complete message received |
| bus_free | input | 1 | Target released the bus |
| resel | input | 1 | A target reselected this initiator |
| resel_id | input | ID_W | ID of the reselecting target |
| sel_in | input | 1 | This initiator was selected |
| cfg_hpe | input | 1 | Halt on data parity error |
| cfg_aape | input | 1 | Raise ATN on data parity error |
| cfg_hd | input | 1 | End the command on disconnect |
| state_code | output | 4 | Visible command state code |
| atn | output | 1 | ATN drive |
| cnt_dec | output | 1 | Transfer counter decremented |
| irq_halt | output | 1 | Halted interrupt pulse |
| irq_par | output | 1 | Parity-error interrupt pulse |
| irq_disc | output | 1 | Disconnected interrupt pulse |
| irq_resel | output | 1 | Reselected-by-other interrupt pulse |
| irq_sel | output | 1 | Selected interrupt pulse |
| irq_ctl_err | output | 1 | Control-error interrupt pulse |

## Verification
The bench builds the block with a 6-bit count and 3-bit IDs. With a 6-bit count, short transfers of one to five bytes reach the code-B boundary within a few cycles. They also put the resume-after-reconnect count within a directed test: one byte moves before the disconnect and the rest move after. The 3-bit IDs leave room for a foreign target to reselect while the armed target is waiting, which exercises the compare that separates a true reconnect from a foreign reselection.

// File: rtl/dps_pkg.sv
// Shared state type and visible command state codes for the sequencer.
package dps_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_ARMED, ST_DATA, ST_SAVED, ST_DMSG,
        ST_DISC, ST_DONE, ST_HALT, ST_ERR
    } seq_st_t;

    localparam logic [3:0] CODE_RESET = 4'h0;
    localparam logic [3:0] CODE_ARMED = 4'h4;
    localparam logic [3:0] CODE_DATA  = 4'h5;
    localparam logic [3:0] CODE_SAVED = 4'h6;
    localparam logic [3:0] CODE_DMSG  = 4'h7;
    localparam logic [3:0] CODE_DISC  = 4'h8;
    localparam logic [3:0] CODE_DONE  = 4'hB;
endpackage

// File: rtl/dps_xfer_cnt.sv
// Transfer down-counter. It loads the byte count when a command is armed and
// steps down once per accepted data byte.
// Assumes: load and dec are never high together, and the loaded count is nonzero.
module dps_xfer_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             dec,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Hold the remaining byte count.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (load)  cnt_q <= len;
        else if (dec)   cnt_q <= cnt_q - ONE;
    end

    // The next accepted byte empties the counter.
    assign last = (cnt_q == ONE);
endmodule

// File: rtl/dps_ctrl_fsm.sv
// Command sequencer: data phase, pointer save, disconnect and reconnect
// handling, parity policies, state code and interrupt pulses.
// Assumes: event strobes are single-cycle, and message strobes come in with
// bus_data low.
module dps_ctrl_fsm
    import dps_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_start,
    input  logic [ID_W-1:0] tgt_id,
    input  logic            bus_data,
    input  logic            req,
    input  logic            byte_ack,
    input  logic            par_err,
    input  logic            msg_sdp,
    input  logic            msg_disc,
    input  logic            msg_cmplt,
    input  logic            bus_free,
    input  logic            resel,
    input  logic [ID_W-1:0] resel_id,
    input  logic            sel_in,
    input  logic            cfg_hpe,
    input  logic            cfg_aape,
    input  logic            cfg_hd,
    input  logic            cnt_last,
    output logic            cnt_load,
    output logic            cnt_step,
    output logic [3:0]      state_code,
    output logic            atn,
    output logic            cnt_dec,
    output logic            irq_halt,
    output logic            irq_par,
    output logic            irq_disc,
    output logic            irq_resel,
    output logic            irq_sel,
    output logic            irq_ctl_err
);
    seq_st_t         st_q, st_d;
    logic [3:0]      code_q, code_d;
    logic [ID_W-1:0] tgt_q, tgt_d;
    logic            atn_q, atn_d, perr_q, perr_d, cc_q, cc_d;
    logic            halt_d, disc_d, resel_d, sel_d, cerr_d;
    logic            active;

    // A command is in progress and a bus release would matter.
    assign active   = (st_q == ST_ARMED) || (st_q == ST_DATA) || (st_q == ST_SAVED) ||
                      (st_q == ST_DMSG)  || (st_q == ST_DONE);
    // Load the counter when a new command is accepted.
    assign cnt_load = cmd_start && ((st_q == ST_IDLE) || (st_q == ST_HALT));
    // Count a data byte unless halt-on-parity rejects it.
    assign cnt_step = (st_q == ST_DATA) && bus_data && byte_ack && !bus_free &&
                      !(par_err && cfg_hpe);

    // Next-state, code and event decision for one cycle.
    always_comb begin
        st_d    = st_q;
        code_d  = code_q;
        tgt_d   = tgt_q;
        atn_d   = atn_q;
        perr_d  = perr_q;
        cc_d    = cc_q;
        halt_d  = 1'b0;
        disc_d  = 1'b0;
        resel_d = 1'b0;
        sel_d   = 1'b0;
        cerr_d  = 1'b0;
        if (active && bus_free && !(st_q == ST_DMSG) && !(st_q == ST_DONE && cc_q)) begin
            cerr_d = 1'b1;
            code_d = CODE_DISC;
            st_d   = ST_ERR;
        end else if (active && !bus_data && par_err) begin
            halt_d = 1'b1;
            st_d   = ST_HALT;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_HALT: if (cmd_start) begin
                    st_d   = ST_ARMED;
                    code_d = CODE_ARMED;
                    tgt_d  = tgt_id;
                    atn_d  = 1'b0;
                    perr_d = 1'b0;
                    cc_d   = 1'b0;
                end
                ST_ARMED, ST_SAVED: begin
                    if (msg_disc) begin
                        st_d   = ST_DMSG;
                        code_d = CODE_DMSG;
                    end else if (req && bus_data) begin
                        st_d   = ST_DATA;
                        code_d = CODE_DATA;
                    end
                end
                ST_DATA: begin
                    if (bus_data && byte_ack) begin
                        if (par_err) begin
                            atn_d  = atn_q | cfg_aape;
                            perr_d = 1'b1;
                        end
                        if (par_err && cfg_hpe) begin
                            halt_d = 1'b1;
                            st_d   = ST_HALT;
                        end else if (cnt_last) begin
                            code_d = CODE_DONE;
                            halt_d = perr_q | par_err;
                            st_d   = (perr_q | par_err) ? ST_HALT : ST_DONE;
                        end
                    end else if (!bus_data && perr_q) begin
                        halt_d = 1'b1;
                        st_d   = ST_HALT;
                    end else if (msg_sdp) begin
                        st_d   = ST_SAVED;
                        code_d = CODE_SAVED;
                    end
                end
                ST_DMSG: if (bus_free) begin
                    code_d = CODE_DISC;
                    disc_d = cfg_hd;
                    st_d   = cfg_hd ? ST_IDLE : ST_DISC;
                end
                ST_DISC: begin
                    if (resel && (resel_id == tgt_q)) begin
                        st_d   = ST_DATA;
                        code_d = CODE_DATA;
                    end else if (resel) begin
                        resel_d = 1'b1;
                    end else if (sel_in) begin
                        sel_d = 1'b1;
                    end
                end
                ST_DONE: begin
                    if (bus_free) st_d = ST_IDLE;
                    else if (msg_cmplt) cc_d = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Register state, code, ATN and the one-cycle event outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            code_q      <= CODE_RESET;
            tgt_q       <= '0;
            atn_q       <= 1'b0;
            perr_q      <= 1'b0;
            cc_q        <= 1'b0;
            cnt_dec     <= 1'b0;
            irq_halt    <= 1'b0;
            irq_par     <= 1'b0;
            irq_disc    <= 1'b0;
            irq_resel   <= 1'b0;
            irq_sel     <= 1'b0;
            irq_ctl_err <= 1'b0;
        end else begin
            st_q        <= st_d;
            code_q      <= code_d;
            tgt_q       <= tgt_d;
            atn_q       <= atn_d;
            perr_q      <= perr_d;
            cc_q        <= cc_d;
            cnt_dec     <= cnt_step;
            irq_halt    <= halt_d;
            irq_par     <= halt_d;
            irq_disc    <= disc_d;
            irq_resel   <= resel_d;
            irq_sel     <= sel_d;
            irq_ctl_err <= cerr_d;
        end
    end

    assign state_code = code_q;
    assign atn        = atn_q;
endmodule

// File: rtl/dp_disc_seq.sv
// Top of the data-phase and disconnect sequencer: joins the command FSM to
// the transfer counter.
// Assumes: a single clock domain and event strobes synchronous to clk.
module dp_disc_seq #(
    parameter int CNT_W = 16,
    parameter int ID_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic [ID_W-1:0]  tgt_id,
    input  logic             bus_data,
    input  logic             req,
    input  logic             byte_ack,
    input  logic             par_err,
    input  logic             msg_sdp,
    input  logic             msg_disc,
    input  logic             msg_cmplt,
    input  logic             bus_free,
    input  logic             resel,
    input  logic [ID_W-1:0]  resel_id,
    input  logic             sel_in,
    input  logic             cfg_hpe,
    input  logic             cfg_aape,
    input  logic             cfg_hd,
    output logic [3:0]       state_code,
    output logic             atn,
    output logic             cnt_dec,
    output logic             irq_halt,
    output logic             irq_par,
    output logic             irq_disc,
    output logic             irq_resel,
    output logic             irq_sel,
    output logic             irq_ctl_err
);
    logic cnt_load, cnt_step, cnt_last;

    dps_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cnt_load),
        .len  (xfer_len),
        .dec  (cnt_step),
        .last (cnt_last)
    );

    dps_ctrl_fsm #(.ID_W(ID_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .tgt_id     (tgt_id),
        .bus_data   (bus_data),
        .req        (req),
        .byte_ack   (byte_ack),
        .par_err    (par_err),
        .msg_sdp    (msg_sdp),
        .msg_disc   (msg_disc),
        .msg_cmplt  (msg_cmplt),
        .bus_free   (bus_free),
        .resel      (resel),
        .resel_id   (resel_id),
        .sel_in     (sel_in),
        .cfg_hpe    (cfg_hpe),
        .cfg_aape   (cfg_aape),
        .cfg_hd     (cfg_hd),
        .cnt_last   (cnt_last),
        .cnt_load   (cnt_load),
        .cnt_step   (cnt_step),
        .state_code (state_code),
        .atn        (atn),
        .cnt_dec    (cnt_dec),
        .irq_halt   (irq_halt),
        .irq_par    (irq_par),
        .irq_disc   (irq_disc),
        .irq_resel  (irq_resel),
        .irq_sel    (irq_sel),
        .irq_ctl_err(irq_ctl_err)
    );
endmodule

// File: rtl/dp_disc_seq_chk.sv
// Property checker for the sequencer, attached by bind.
module dp_disc_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_ack,
    input logic       par_err,
    input logic       cfg_aape,
    input logic [3:0] state_code,
    input logic       atn,
    input logic       cnt_dec,
    input logic       irq_halt,
    input logic       irq_par,
    input logic       irq_disc,
    input logic       irq_resel,
    input logic       irq_sel,
    input logic       irq_ctl_err
);
    logic err_seen;

    // Remember that a control error has occurred since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           err_seen <= 1'b0;
        else if (irq_ctl_err) err_seen <= 1'b1;
    end

    // R3
    dec_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_dec |-> $past(byte_ack));
    // R5
    halt_with_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_halt |-> irq_par);
    // R6
    atn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(atn) |-> ($past(par_err) && $past(cfg_aape)));
    // R8
    disc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_disc |-> (state_code == 4'h8));
    // R10
    foreign_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_resel || irq_sel) |-> (state_code == 4'h8));
    // R11
    err_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_seen |-> (!cnt_dec && !irq_halt && !irq_disc && state_code == 4'h8));
    // R13
    halt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_halt |=> !irq_halt);
endmodule

bind dp_disc_seq dp_disc_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_ack   (byte_ack),
    .par_err    (par_err),
    .cfg_aape   (cfg_aape),
    .state_code (state_code),
    .atn        (atn),
    .cnt_dec    (cnt_dec),
    .irq_halt   (irq_halt),
    .irq_par    (irq_par),
    .irq_disc   (irq_disc),
    .irq_resel  (irq_resel),
    .irq_sel    (irq_sel),
    .irq_ctl_err(irq_ctl_err)
);

// File: tb/tb_dp_disc_seq.sv
`timescale 1ns/1ps
module tb_dp_disc_seq;
    localparam int CW = 6;
    localparam int IW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_start = 0, bus_data = 0, req = 0, byte_ack = 0, par_err = 0;
    logic msg_sdp = 0, msg_disc = 0, msg_cmplt = 0, bus_free = 0, resel = 0, sel_in = 0;
    logic cfg_hpe = 0, cfg_aape = 0, cfg_hd = 0;
    logic [CW-1:0] xfer_len = '0;
    logic [IW-1:0] tgt_id = '0, resel_id = '0;
    logic [3:0] state_code;
    logic atn, cnt_dec, irq_halt, irq_par, irq_disc, irq_resel, irq_sel, irq_ctl_err;
    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    dp_disc_seq #(.CNT_W(CW), .ID_W(IW)) dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        cmd_start = 0; req = 0; byte_ack = 0; par_err = 0; msg_sdp = 0;
        msg_disc = 0; msg_cmplt = 0; bus_free = 0; resel = 0; sel_in = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; bus_data = 0; step(); step(); rst_n = 1; step();
    endtask

    task automatic arm(input int len, input int id);
        cmd_start = 1; xfer_len = CW'(len); tgt_id = IW'(id); step();
    endtask

    task automatic enter_data();
        bus_data = 1; req = 1; step();
    endtask

    task automatic send_byte(input logic bad);
        bus_data = 1; byte_ack = 1; par_err = bad; step();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 code", state_code, 0);
        chk("R1 atn", atn, 0);
        chk("R1 pulses", {cnt_dec, irq_halt, irq_par, irq_disc, irq_resel, irq_sel, irq_ctl_err}, 0);
    endtask

    task automatic t_normal();
        do_reset(); cfg_hpe = 0; cfg_aape = 0;
        arm(3, 2);
        chk("R2 armed", state_code, 4);
        enter_data();
        chk("R2 data", state_code, 5);
        send_byte(0); chk("R3 dec1", cnt_dec, 1); chk("R3 code", state_code, 5);
        step();       chk("R13 dec pulse", cnt_dec, 0);
        send_byte(0); chk("R3 dec2", cnt_dec, 1);
        send_byte(0); chk("R3 dec3", cnt_dec, 1); chk("R3 done", state_code, 4'hB);
        bus_data = 0; msg_cmplt = 1; step();
        bus_free = 1; step();
        chk("R12 no ctl err", irq_ctl_err, 0); chk("R12 code", state_code, 4'hB);
        arm(2, 1);
        chk("R12 rearm", state_code, 4);
    endtask

    task automatic t_hpe();
        do_reset(); cfg_hpe = 1; cfg_aape = 1;
        arm(4, 1); enter_data();
        send_byte(0);
        send_byte(1);
        chk("R4 halt", irq_halt, 1); chk("R4 par", irq_par, 1);
        chk("R4 no dec", cnt_dec, 0); chk("R4 code", state_code, 5);
        chk("R6 atn", atn, 1);
        send_byte(0);
        chk("R13 halt pulse", irq_halt, 0); chk("R4 ignored byte", cnt_dec, 0);
        chk("R6 atn held", atn, 1);
        arm(2, 1);
        chk("R6 atn cleared", atn, 0);
    endtask

    task automatic t_hpe0_last();
        do_reset(); cfg_hpe = 0; cfg_aape = 0;
        arm(2, 3); enter_data();
        send_byte(1);
        chk("R5 bad byte counted", cnt_dec, 1); chk("R5 no halt yet", irq_halt, 0);
        chk("R6 no atn", atn, 0);
        send_byte(0);
        chk("R5 halt last", irq_halt, 1); chk("R5 par last", irq_par, 1);
        chk("R5 code B", state_code, 4'hB);
    endtask

    task automatic t_hpe0_phase();
        do_reset(); cfg_hpe = 0; cfg_aape = 1;
        arm(5, 3); enter_data();
        send_byte(1);
        chk("R6 atn data", atn, 1); chk("R5 no halt", irq_halt, 0);
        bus_data = 0; step();
        chk("R5 phase halt", irq_halt, 1); chk("R5 phase par", irq_par, 1);
        chk("R5 phase code", state_code, 5);
    endtask

    task automatic t_msg_parity();
        do_reset(); cfg_hpe = 0; cfg_aape = 1;
        arm(3, 2);
        bus_data = 0; par_err = 1; step();
        chk("R6 msg halt", irq_halt, 1); chk("R6 msg par", irq_par, 1);
        chk("R6 msg no atn", atn, 0);
    endtask

    task automatic t_disc_hd1();
        do_reset(); cfg_hd = 1; cfg_hpe = 0; cfg_aape = 0;
        arm(4, 2);
        bus_data = 0; msg_disc = 1; step();
        chk("R7 disc after arm", state_code, 7);
        do_reset();
        arm(4, 2); enter_data(); send_byte(0);
        bus_data = 0; msg_sdp = 1; step();
        chk("R7 saved", state_code, 6);
        msg_disc = 1; step();
        chk("R7 disc msg", state_code, 7);
        bus_free = 1; step();
        chk("R8 disc irq", irq_disc, 1); chk("R8 code", state_code, 8);
        step();
        chk("R13 disc pulse", irq_disc, 0);
    endtask

    task automatic t_reconnect();
        do_reset(); cfg_hd = 0; cfg_hpe = 0;
        arm(3, 5); enter_data(); send_byte(0);
        bus_data = 0; msg_sdp = 1; step();
        bus_data = 1; req = 1; step();
        chk("R7 resume after save", state_code, 5);
        bus_data = 0; msg_sdp = 1; step();
        msg_disc = 1; step();
        bus_free = 1; step();
        chk("R8 hd0 no irq", irq_disc, 0); chk("R8 hd0 code", state_code, 8);
        resel = 1; resel_id = 3'd3; step();
        chk("R10 resel irq", irq_resel, 1); chk("R10 resel code", state_code, 8);
        sel_in = 1; step();
        chk("R10 sel irq", irq_sel, 1); chk("R10 sel code", state_code, 8);
        chk("R13 resel pulse", irq_resel, 0);
        resel = 1; resel_id = 3'd5; step();
        chk("R9 reconnect", state_code, 5);
        send_byte(0);
        chk("R9 dec", cnt_dec, 1); chk("R9 not done", state_code, 5);
        send_byte(0);
        chk("R9 done", state_code, 4'hB);
    endtask

    task automatic t_ctl_err();
        do_reset(); cfg_hd = 0;
        arm(4, 2); enter_data(); send_byte(0);
        bus_data = 0; msg_disc = 1; step();
        chk("R7 disc ignored in data", state_code, 5);
        bus_free = 1; step();
        chk("R11 ctl err", irq_ctl_err, 1); chk("R11 code", state_code, 8);
        arm(3, 1);
        chk("R11 start ignored", state_code, 8);
        enter_data(); send_byte(0);
        chk("R11 byte ignored", cnt_dec, 0); chk("R11 locked", state_code, 8);
        do_reset();
        chk("R11 reset clears", state_code, 0);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_hpe();
        t_hpe0_last();
        t_hpe0_phase();
        t_msg_parity();
        t_disc_hd1();
        t_reconnect();
        t_ctl_err();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule